// File: doc/BRIEF.md
# GPIO Controller with Edge Interrupts

A 32-line general-purpose I/O controller on a plain 32-bit register bus. Each line has its own 4-bit configuration field. The field holds the value to drive, a direction bit and a read-only copy of the sampled pin level. Every pin goes through a two-flop synchroniser. A previous-value register after the synchroniser detects rising and falling edges.

Each edge kind sets its own sticky status bit. Lines 0–15 form one interrupt bank and lines 16–31 form the other. Software clears a status bit by writing 1 to it, and an enable register per bank gates which status bits reach the interrupt. The single interrupt output is level-sensitive: it stays high until every enabled pending bit has been cleared.

The usual sequence is:
1. Configure the lines.
2. Clear any stale status.
3. Set the enable bits.
4. Service the interrupt by reading status and writing the handled bits back.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Word addresses 0, 1, 2 and 3 hold the configuration of lines 0–7, 8–15, 16–23 and 24–31. A line's 4-bit field starts at bit 4×(line mod 8). Field bit 0 is the output value and appears on `gpio_out[line]`.
- R2: Field bit 1 set means the line is an input. `gpio_oe[line]` is the inverse of that bit, so writing 0 to bit 1 turns the driver on.
- R3: Field bit 2 reads the pin level after a two-flop synchroniser. Field bit 3 reads 0. Writes to bits 2 and 3 have no effect.
- R4: Bank 0 covers lines 0–15 and bank 1 covers lines 16–31. Bank 0 has its enable register at address 4 and its status register at address 5; bank 1 uses addresses 6 and 7. For the line at position n within a bank, a rising edge of the synchronised level sets status bit n and a falling edge sets status bit n+16.
- R5: Writing a 1 to a status bit clears it. Writing a 0 to a status bit leaves it unchanged.
- R6: If an edge sets a status bit in the same cycle that a write of 1 clears it, the bit ends up set.
- R7: `irq` is the OR over both banks of (status AND enable). Status bits are recorded even when their enable bit is 0, but they do not raise `irq` then.
- R8: After reset every line is an input (bit 1 = 1) with output value 0, and all enable and status bits are 0.
- R9: Writes to addresses 8–15 change nothing, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| gpio_in | input | 32 | Pin levels from the pads |
| gpio_out | output | 32 | Output values to drive |
| gpio_oe | output | 32 | Output driver enables, active high |
| irq | output | 1 | Combined level interrupt |

## Verification
A wrong synchroniser or edge register shows up as a status bit that sets one cycle early or late, or in the wrong half of the word. The bench catches this because it aligns a clearing write to the exact cycle in which the edge lands. A wrong clear/set priority or enable mask shows up at `irq` and at the status readback on the first bus access after the event. Configuration faults show up on `gpio_out` and `gpio_oe` one clock after the write, checked with several patterns across all 32 lines.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W        = 4;
  localparam int DATA_W        = 32;
  localparam int LINES_PER_REG = 8;
  localparam int BANK_LINES    = 16;
  localparam int FLD_W         = 4;
  // field bit positions within a line's configuration field
  localparam int FLD_OUT       = 0;
  localparam int FLD_INPUT     = 1;
  localparam int FLD_LEVEL     = 2;
  // first interrupt-bank word; bank b: enable at IRQ_BASE+2b, status at +1
  localparam int IRQ_BASE      = 4;
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pin_in,
  output logic [N_LINES-1:0] level,
  output logic [N_LINES-1:0] rise,
  output logic [N_LINES-1:0] fall
);
  logic [N_LINES-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
  assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_edge_pkg::*;
#(
  parameter  int N_LINES = 32,
  localparam int N_REGS  = N_LINES / LINES_PER_REG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_REGS-1:0]  reg_we,
  input  logic [DATA_W-1:0]  wdata,
  output logic [N_LINES-1:0] out_val,
  output logic [N_LINES-1:0] dir_in
);
  logic [N_LINES-1:0] out_q, out_d, dir_q, dir_d;

  generate
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
      localparam int REG = i / LINES_PER_REG;
      localparam int SH  = (i % LINES_PER_REG) * FLD_W;
      always_comb begin
        out_d[i] = out_q[i];
        dir_d[i] = dir_q[i];
        if (reg_we[REG]) begin
          out_d[i] = wdata[SH + FLD_OUT];
          dir_d[i] = wdata[SH + FLD_INPUT];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '1;
    end else begin
      out_q <= out_d;
      dir_q <= dir_d;
    end
  end

  assign out_val = out_q;
  assign dir_in  = dir_q;

  // R1: configuration holds when no configuration word is written
  a_r1_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we == '0) |=> ($stable(out_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter  int HALF = 16,
  localparam int W    = 2 * HALF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_we,
  input  logic            st_we,
  input  logic [W-1:0]    wdata,
  input  logic [HALF-1:0] rise,
  input  logic [HALF-1:0] fall,
  output logic [W-1:0]    en_q,
  output logic [W-1:0]    st_q,
  output logic            pend
);
  logic [W-1:0] en_d, st_d, set_v, clr_v;

  always_comb begin
    set_v = {fall, rise};
    clr_v = st_we ? wdata : '0;
    st_d  = (st_q & ~clr_v) | set_v;   // a new edge beats a clear
    en_d  = en_we ? wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      en_q <= en_d;
      st_q <= st_d;
    end
  end

  assign pend = |(st_q & en_q);

  // R6: every bit an edge sets is set on the next cycle, whatever the write
  a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((st_q & $past(set_v)) == $past(set_v)));

  // R5: status bits written with 0 keep their value
  a_r5_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> ((st_q & $past(st_q & ~wdata)) == $past(st_q & ~wdata)));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [31:0]       gpio_in,
  output logic [31:0]       gpio_out,
  output logic [31:0]       gpio_oe,
  output logic              irq
);
  localparam int N_LINES = 32;
  localparam int N_CTRL  = N_LINES / LINES_PER_REG;
  localparam int N_BANK  = N_LINES / BANK_LINES;
  localparam int MAP_TOP = IRQ_BASE + 2 * N_BANK;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic [N_LINES-1:0] lvl, rise, fall, out_val, dir_in;
  logic [N_CTRL-1:0]  ctrl_we;
  logic [N_BANK-1:0]  en_we, st_we, pend;
  logic [N_BANK-1:0][DATA_W-1:0] en_all, st_all;

  gpio_sync_edge #(.N_LINES(N_LINES)) u_sync (
    .clk(clk), .rst_n(rst_s), .pin_in(gpio_in),
    .level(lvl), .rise(rise), .fall(fall));

  always_comb begin
    for (int r = 0; r < N_CTRL; r++)
      ctrl_we[r] = wr_en && (addr == ADDR_W'(r));
    for (int b = 0; b < N_BANK; b++) begin
      en_we[b] = wr_en && (addr == ADDR_W'(IRQ_BASE + 2 * b));
      st_we[b] = wr_en && (addr == ADDR_W'(IRQ_BASE + 2 * b + 1));
    end
  end

  gpio_pin_cfg #(.N_LINES(N_LINES)) u_cfg (
    .clk(clk), .rst_n(rst_s), .reg_we(ctrl_we), .wdata(wdata),
    .out_val(out_val), .dir_in(dir_in));

  generate
    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      gpio_irq_bank #(.HALF(BANK_LINES)) u_bank (
        .clk(clk), .rst_n(rst_s),
        .en_we(en_we[b]), .st_we(st_we[b]), .wdata(wdata),
        .rise(rise[b*BANK_LINES +: BANK_LINES]),
        .fall(fall[b*BANK_LINES +: BANK_LINES]),
        .en_q(en_all[b]), .st_q(st_all[b]), .pend(pend[b]));
    end
  endgenerate

  assign gpio_out = out_val;
  assign gpio_oe  = ~dir_in;
  assign irq      = |pend;

  always_comb begin
    rdata = '0;
    for (int r = 0; r < N_CTRL; r++) begin
      if (addr == ADDR_W'(r)) begin
        for (int k = 0; k < LINES_PER_REG; k++) begin
          rdata[k*FLD_W + FLD_OUT]   = out_val[r*LINES_PER_REG + k];
          rdata[k*FLD_W + FLD_INPUT] = dir_in[r*LINES_PER_REG + k];
          rdata[k*FLD_W + FLD_LEVEL] = lvl[r*LINES_PER_REG + k];
        end
      end
    end
    for (int b = 0; b < N_BANK; b++) begin
      if (addr == ADDR_W'(IRQ_BASE + 2 * b))     rdata = en_all[b];
      if (addr == ADDR_W'(IRQ_BASE + 2 * b + 1)) rdata = st_all[b];
    end
  end

  // R9: writes past the map leave configuration and enables untouched
  a_r9_bad_addr_inert: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en && (addr >= ADDR_W'(MAP_TOP))) |=>
      ($stable(gpio_out) && $stable(gpio_oe) && $stable(en_all)));

  // R7: no interrupt while every enable bit is clear
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_s)
    (en_all == '0) |-> !irq);
endmodule

// File: tb/sim_gpio_edge_ctrl.sv
module sim_gpio_edge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata, gpio_in, gpio_out, gpio_oe;
  logic        irq;
  int          n_total = 0;
  int          n_fail  = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  gpio_edge_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // expected configuration word readback from write pattern and pin levels
  function automatic logic [31:0] cfg_exp(input logic [31:0] p, input logic [31:0] pins, input int r);
    logic [31:0] e;
    e = p & 32'h3333_3333;
    for (int k = 0; k < 8; k++) e[4*k+2] = pins[r*8+k];
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    logic [31:0] d, exp_out, exp_oe;
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5C3_1E69;
    pats[2] = 32'h5555_5555; pats[3] = 32'h0000_0000;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; gpio_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset state
    chk("R8 gpio_oe", gpio_oe, 32'h0);
    chk("R8 gpio_out", gpio_out, 32'h0);
    chk("R8 irq", {31'b0, irq}, 32'h0);
    for (int r = 0; r < 4; r++) begin
      bus_rd(4'(r), d); chk("R8 cfg word", d, 32'h2222_2222);
    end
    for (int a = 4; a < 8; a++) begin
      bus_rd(4'(a), d); chk("R8 irq word", d, 32'h0);
    end

    // R1 R2 R3 configuration sweep
    foreach (pats[p]) begin
      for (int r = 0; r < 4; r++) bus_wr(4'(r), pats[p]);
      for (int i = 0; i < 32; i++) begin
        exp_out[i] = pats[p][(i%8)*4];
        exp_oe[i]  = ~pats[p][(i%8)*4+1];
      end
      chk("R1 gpio_out", gpio_out, exp_out);
      chk("R2 gpio_oe", gpio_oe, exp_oe);
      gpio_in = pats[p] ^ 32'h0F0F_3C3C;
      settle();
      for (int r = 0; r < 4; r++) begin
        bus_rd(4'(r), d);
        chk("R3 cfg readback", d, cfg_exp(pats[p], gpio_in, r));
      end
      @(negedge clk) gpio_in = '0;
      settle();
      bus_wr(4'd5, 32'hFFFF_FFFF);
      bus_wr(4'd7, 32'hFFFF_FFFF);
    end

    // R9 out-of-map accesses
    bus_wr(4'd0, 32'h1111_2222);
    for (int a = 8; a < 16; a++) bus_wr(4'(a), 32'hFFFF_FFFF);
    for (int a = 8; a < 16; a++) begin
      bus_rd(4'(a), d); chk("R9 read zero", d, 32'h0);
    end
    bus_rd(4'd0, d); chk("R9 cfg unchanged", d, 32'h1111_2222);
    bus_rd(4'd4, d); chk("R9 enable0 unchanged", d, 32'h0);
    bus_rd(4'd6, d); chk("R9 enable1 unchanged", d, 32'h0);
    chk("R9 gpio_oe", gpio_oe, 32'hFFFF_FFF0);

    // R4 R5 R7 edge sweep over every line
    for (int l = 0; l < 32; l++) begin
      logic [3:0] ea, sa, oa;
      int n;
      n  = l % 16;
      ea = 4'(4 + 2*(l/16));
      sa = ea + 4'd1;
      oa = (l < 16) ? 4'd7 : 4'd5;
      @(negedge clk) gpio_in[l] = 1'b1;
      settle();
      bus_rd(sa, d); chk("R4 rise bit", d, 32'h1 << n);
      bus_rd(oa, d); chk("R4 other bank quiet", d, 32'h0);
      chk("R7 disabled no irq", {31'b0, irq}, 32'h0);
      bus_wr(ea, 32'h1 << n);
      chk("R7 enabled irq", {31'b0, irq}, 32'h1);
      bus_wr(sa, 32'h0);
      bus_rd(sa, d); chk("R5 zero keeps", d, 32'h1 << n);
      bus_wr(sa, 32'h1 << n);
      bus_rd(sa, d); chk("R5 one clears", d, 32'h0);
      chk("R7 irq drops", {31'b0, irq}, 32'h0);
      @(negedge clk) gpio_in[l] = 1'b0;
      settle();
      bus_rd(sa, d); chk("R4 fall bit", d, 32'h1 << (n + 16));
      chk("R7 fall masked", {31'b0, irq}, 32'h0);
      bus_wr(ea, 32'h1 << (n + 16));
      chk("R7 fall irq", {31'b0, irq}, 32'h1);
      bus_wr(sa, 32'hFFFF_FFFF);
      chk("R7 irq after clear", {31'b0, irq}, 32'h0);
      bus_wr(ea, 32'h0);
    end

    // R6 edge landing in the same cycle as a clearing write
    @(negedge clk) gpio_in[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) begin wr_en = 1'b1; addr = 4'd5; wdata = 32'h0000_0008; end
    @(negedge clk) wr_en = 1'b0;
    bus_rd(4'd5, d); chk("R6 edge beats clear", d, 32'h0000_0008);
    bus_wr(4'd5, 32'h0000_0008);
    bus_rd(4'd5, d); chk("R6 later clear works", d, 32'h0);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule